// File: doc/BRIEF.md
# External Master Bridge to Internal Bus

This block lets an alternate bus master on the external bus reach the slaves on the chip's internal system bus. It watches external cycle starts while the external master holds the bus grant. When the address falls inside the relocatable internal window, it carries out a single read or write on the internal bus. Every accepted cycle is closed with exactly one termination: acknowledge, error or retry.

Two operating modes are held in a small mode register. In halted-core mode the internal CPU loses access to the internal bus. In shared mode the CPU keeps running and competes with the external master on a first-come basis. Reset can select halted-core mode through a configuration input. The mode register sits at a fixed word inside the window and stays reachable with both modes off, so an external master can set the mode before it does anything else.

There is a deadlock case: an internal-to-external access is in flight when an external cycle starts. The bridge then retries the external master and refuses new CPU requests for a fixed lockout window so that pending traffic can drain.

Top module: `xmb_bridge`

## Requirements
- R1: At reset the mode register holds halted-core = `cfg_halt_rst` and shared = 0. `cpu_halt` always equals the halted-core bit (mode register bit 1), and `cpu_gnt` is never high while it is set.
- R2: With shared mode on (bit 0 = 1, bit 1 = 0), `cpu_gnt` follows `cpu_req` whenever the bridge is idle and no lockout is active, and in-window cycles are still forwarded.
- R3: An accepted cycle with `ext_burst` high is carried out as a single transfer, and `ext_bi` is high in the same cycle as its `ext_ta` or `ext_tea`. A retry never raises `ext_bi`.
- R4: A start (`ext_ts`) is recognised only when the bridge is idle, `ext_bg` is high, and address bits [ADDR_W-1:ADDR_W-BASE_W] equal `map_base`. A non-mode-register address also needs one of the two mode bits set. An unrecognised start causes no `int_req` and no termination.
- R5: Each recognised start produces exactly one single-cycle pulse, on one of `ext_ta`, `ext_tea` or `ext_retry`. A forwarded cycle terminates in the cycle after the slave's response is sampled.
- R6: If `ie_busy` is high when a non-mode-register start is recognised, `ext_retry` pulses in the next cycle and nothing is forwarded.
- R7: After a retry start, `cpu_gnt` stays low for the next LOCK_CYC (8) cycles.
- R8: A forwarded cycle that gets neither `int_ack` nor `int_err` within TMO_CYC (16) cycles of `int_req` ends with `ext_tea`.
- R9: `int_be` bit i enables `int_wdata[8i+7:8i]`, in big-endian order (byte address a maps to lane 3-a). Size codes: 0 = byte gives lane 3-a; 1 = half gives 4'b1100 when a[1]=0 and 4'b0011 otherwise; 2 or 3 = word gives 4'b1111.
- R10: The mode register sits at window offset CTRL_OFS (0), word-decoded, and is reached whatever the mode and `ie_busy`. It terminates with `ext_ta` one cycle after the start. A write loads `ext_wdata[1:0]` (taking precedence over `sw_we`); a read returns the register in `ext_rdata[1:0]` with the upper bits zero.
- R11: An `int_err` sampled during a forwarded cycle ends it with `ext_tea`.
- R12: `int_req` is high from the cycle after a forwarding start until the cycle that samples the response. A forwarded read returns the sampled `int_rdata` on `ext_rdata` with `ext_ta`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_halt_rst | input | 1 | Reset value of the halted-core mode bit |
| map_base | input | BASE_W | Internal window base, from the memory-map register |
| sw_we | input | 1 | CPU write strobe for the mode register |
| sw_wdata | input | 2 | CPU write data {halted-core, shared} |
| ext_bg | input | 1 | External master holds bus grant |
| ext_ts | input | 1 | External cycle start |
| ext_addr | input | ADDR_W | External address |
| ext_we | input | 1 | External write (1) or read (0) |
| ext_size | input | 2 | Transfer size code |
| ext_burst | input | 1 | External master requests a burst |
| ext_wdata | input | DATA_W | External write data |
| ext_ta | output | 1 | Transfer acknowledge pulse |
| ext_tea | output | 1 | Transfer error pulse |
| ext_retry | output | 1 | Retry pulse |
| ext_bi | output | 1 | Burst inhibit, with the termination |
| ext_rdata | output | DATA_W | Read data, valid with ext_ta |
| int_req | output | 1 | Internal bus request |
| int_addr | output | ADDR_W | Internal address |
| int_we | output | 1 | Internal write |
| int_be | output | 4 | Internal byte lane enables |
| int_wdata | output | DATA_W | Internal write data |
| int_ack | input | 1 | Internal slave acknowledge |
| int_err | input | 1 | Internal slave error |
| int_rdata | input | DATA_W | Internal read data |
| ie_busy | input | 1 | Internal-to-external access in progress |
| cpu_req | input | 1 | CPU requests the internal bus |
| cpu_gnt | output | 1 | CPU granted the internal bus |
| cpu_halt | output | 1 | CPU halted |

## Verification
The mode-register access and the retry terminate one cycle after the start edge. `int_req` rises one cycle after the start, and a forwarded cycle terminates one cycle after the edge that samples `int_ack` or `int_err`, or on the sixteenth edge of waiting. The lockout covers the eight cycles that follow the retry start edge. The bench drives inputs two time units after each rising edge. At each rising edge its reference model updates from those inputs, and at the falling edge the model's expectations are compared against every output, so each result is checked in exactly the cycle it is due.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FWD  = 1'b1
   } brg_state_e;

   // bit 1: halted-core mode, bit 0: shared mode
   typedef struct packed {
      logic halt;
      logic shared;
   } mode_t;

   // big-endian lanes: byte address 0 sits in lane 3
   function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] a);
      logic [3:0] m;
      case (xfer_size_e'(sz))
         SZ_BYTE: m = 4'b1000 >> a;
         SZ_HALF: m = a[1] ? 4'b0011 : 4'b1100;
         default: m = 4'b1111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/xmb_decode.sv
module xmb_decode #(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned BASE_W   = 4,
   parameter int unsigned CTRL_OFS = 0
) (
   input  logic [ADDR_W-1:2]           addr_w,
   input  logic [(BASE_W>0?BASE_W:1)-1:0] map_base,
   output logic                        in_win,
   output logic                        ctrl_hit
);
   localparam int unsigned OFS_W = ADDR_W - BASE_W;
   localparam logic [OFS_W-1:0] CTRL_OFS_V = OFS_W'(CTRL_OFS);

   generate
      if (OFS_W < 3) begin : g_bad_window
         $error("xmb_decode: window offset must be at least 3 bits");
      end
      if (BASE_W == 0) begin : g_flat
         assign in_win = 1'b1;
      end else begin : g_based
         assign in_win = (addr_w[ADDR_W-1 -: BASE_W] == map_base);
      end
   endgenerate

   assign ctrl_hit = in_win && (addr_w[OFS_W-1:2] == CTRL_OFS_V[OFS_W-1:2]);

endmodule

// File: rtl/xmb_mode_reg.sv
module xmb_mode_reg
   import xmb_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cfg_halt_rst,
   input  logic  sw_we,
   input  mode_t sw_wdata,
   input  logic  ext_we,
   input  mode_t ext_wdata,
   output mode_t mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode.halt   <= cfg_halt_rst;
         mode.shared <= 1'b0;
      end else if (ext_we) begin
         mode <= ext_wdata;
      end else if (sw_we) begin
         mode <= sw_wdata;
      end
   end

   AST_EXT_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ext_we |=> (mode == $past(ext_wdata))); // R10

endmodule

// File: rtl/xmb_lockout.sv
module xmb_lockout #(
   parameter int unsigned LOCK_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic locked
);
   localparam int unsigned CNT_W = $clog2(LOCK_CYC + 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("xmb_lockout: LOCK_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (start)       cnt <= CNT_W'(LOCK_CYC);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign locked = (cnt != '0);

   AST_LOCK_AFTER_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> locked); // R7

endmodule

// File: rtl/xmb_bridge.sv
module xmb_bridge
   import xmb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned BASE_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CTRL_OFS = 0,
   parameter int unsigned TMO_CYC  = 16,
   parameter int unsigned LOCK_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_halt_rst,
   input  logic [BASE_W-1:0] map_base,
   input  logic              sw_we,
   input  logic [1:0]        sw_wdata,
   input  logic              ext_bg,
   input  logic              ext_ts,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              ext_we,
   input  logic [1:0]        ext_size,
   input  logic              ext_burst,
   input  logic [DATA_W-1:0] ext_wdata,
   output logic              ext_ta,
   output logic              ext_tea,
   output logic              ext_retry,
   output logic              ext_bi,
   output logic [DATA_W-1:0] ext_rdata,
   output logic              int_req,
   output logic [ADDR_W-1:0] int_addr,
   output logic              int_we,
   output logic [3:0]        int_be,
   output logic [DATA_W-1:0] int_wdata,
   input  logic              int_ack,
   input  logic              int_err,
   input  logic [DATA_W-1:0] int_rdata,
   input  logic              ie_busy,
   input  logic              cpu_req,
   output logic              cpu_gnt,
   output logic              cpu_halt
);
   localparam int unsigned TMO_W = $clog2(TMO_CYC);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("xmb_bridge: lane logic assumes a 32-bit data path");
      end
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("xmb_bridge: TMO_CYC must be at least 2");
      end
      if (BASE_W < 1 || BASE_W + 3 > ADDR_W) begin : g_bad_base
         $error("xmb_bridge: BASE_W out of range for ADDR_W");
      end
   endgenerate

   brg_state_e        state;
   mode_t             mode;
   logic              in_win, ctrl_hit, locked;
   logic              start, hit_ctrl, hit_int, retry_now, go_fwd, mode_on;
   logic [TMO_W-1:0]  tmo;
   logic [1:0]        r_size;
   logic              r_burst;

   xmb_decode #(
      .ADDR_W  (ADDR_W),
      .BASE_W  (BASE_W),
      .CTRL_OFS(CTRL_OFS)
   ) u_decode (
      .addr_w  (ext_addr[ADDR_W-1:2]),
      .map_base(map_base),
      .in_win  (in_win),
      .ctrl_hit(ctrl_hit)
   );

   xmb_mode_reg u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_halt_rst(cfg_halt_rst),
      .sw_we       (sw_we),
      .sw_wdata    (mode_t'(sw_wdata)),
      .ext_we      (hit_ctrl && ext_we),
      .ext_wdata   (mode_t'(ext_wdata[1:0])),
      .mode        (mode)
   );

   xmb_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .start (retry_now),
      .locked(locked)
   );

   assign mode_on   = mode.halt || mode.shared;
   assign start     = ext_ts && ext_bg && (state == ST_IDLE);
   assign hit_ctrl  = start && ctrl_hit;
   assign hit_int   = start && in_win && !ctrl_hit && mode_on;
   assign retry_now = hit_int && ie_busy;
   assign go_fwd    = hit_int && !ie_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ext_ta    <= 1'b0;
         ext_tea   <= 1'b0;
         ext_retry <= 1'b0;
         ext_bi    <= 1'b0;
         ext_rdata <= '0;
         tmo       <= '0;
         int_addr  <= '0;
         int_we    <= 1'b0;
         int_wdata <= '0;
         r_size    <= '0;
         r_burst   <= 1'b0;
      end else begin
         ext_ta    <= 1'b0;
         ext_tea   <= 1'b0;
         ext_retry <= 1'b0;
         ext_bi    <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (hit_ctrl) begin
                  ext_ta <= 1'b1;
                  ext_bi <= ext_burst;
                  if (!ext_we) ext_rdata <= DATA_W'(mode);
               end else if (retry_now) begin
                  ext_retry <= 1'b1;
               end else if (go_fwd) begin
                  state     <= ST_FWD;
                  tmo       <= '0;
                  int_addr  <= ext_addr;
                  int_we    <= ext_we;
                  int_wdata <= ext_wdata;
                  r_size    <= ext_size;
                  r_burst   <= ext_burst;
               end
            end
            ST_FWD: begin
               if (int_ack) begin
                  state  <= ST_IDLE;
                  ext_ta <= 1'b1;
                  ext_bi <= r_burst;
                  if (!int_we) ext_rdata <= int_rdata;
               end else if (int_err || tmo == TMO_W'(TMO_CYC - 1)) begin
                  state   <= ST_IDLE;
                  ext_tea <= 1'b1;
                  ext_bi  <= r_burst;
               end else begin
                  tmo <= tmo + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign int_req  = (state == ST_FWD);
   assign int_be   = lane_mask(r_size, int_addr[1:0]);
   assign cpu_halt = mode.halt;
   assign cpu_gnt  = cpu_req && !mode.halt && !locked && (state == ST_IDLE);

   AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ext_ta, ext_tea, ext_retry}) <= 1); // R5

   AST_RETRY_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      ext_retry |-> !int_req); // R6

   AST_HALT_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt |-> !cpu_gnt); // R1

   AST_BI_WITH_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      ext_bi |-> (ext_ta || ext_tea)); // R3

   AST_REQ_ENDS_WITH_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_req) |-> (ext_ta || ext_tea)); // R12

endmodule

// File: tb/xmb_bridge_bench.sv
module xmb_bridge_bench;
   localparam int AW = 24;
   localparam int BW = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_halt_rst = 1'b1;
   logic [BW-1:0] map_base = 4'h3;
   logic          sw_we = 1'b0;
   logic [1:0]    sw_wdata = 2'b00;
   logic          ext_bg = 1'b0, ext_ts = 1'b0, ext_we = 1'b0, ext_burst = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [1:0]    ext_size = 2'd2;
   logic [DW-1:0] ext_wdata = '0;
   logic          ext_ta, ext_tea, ext_retry, ext_bi;
   logic [DW-1:0] ext_rdata;
   logic          int_req, int_we;
   logic [AW-1:0] int_addr;
   logic [3:0]    int_be;
   logic [DW-1:0] int_wdata;
   logic          int_ack = 1'b0, int_err = 1'b0;
   logic [DW-1:0] int_rdata = 32'hCAFE_F00D;
   logic          ie_busy = 1'b0, cpu_req = 1'b1;
   logic          cpu_gnt, cpu_halt;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   xmb_bridge u_xmb_bridge (
      .clk(clk), .rst_n(rst_n), .cfg_halt_rst(cfg_halt_rst), .map_base(map_base),
      .sw_we(sw_we), .sw_wdata(sw_wdata), .ext_bg(ext_bg), .ext_ts(ext_ts),
      .ext_addr(ext_addr), .ext_we(ext_we), .ext_size(ext_size), .ext_burst(ext_burst),
      .ext_wdata(ext_wdata), .ext_ta(ext_ta), .ext_tea(ext_tea), .ext_retry(ext_retry),
      .ext_bi(ext_bi), .ext_rdata(ext_rdata), .int_req(int_req), .int_addr(int_addr),
      .int_we(int_we), .int_be(int_be), .int_wdata(int_wdata), .int_ack(int_ack),
      .int_err(int_err), .int_rdata(int_rdata), .ie_busy(ie_busy), .cpu_req(cpu_req),
      .cpu_gnt(cpu_gnt), .cpu_halt(cpu_halt)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_halt, m_shared, m_fwd, m_cnt, m_lock, m_sz, m_a, m_we, m_burst;
   int m_ta, m_tea, m_retry, m_bi;
   logic [31:0] m_rdata;
   int nx_halt, nx_shared, ctl_wr, lock_ld;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_halt = cfg_halt_rst; m_shared = 0; m_fwd = 0; m_cnt = 0; m_lock = 0;
         m_ta = 0; m_tea = 0; m_retry = 0; m_bi = 0; m_rdata = 0;
         m_sz = 0; m_a = 0; m_we = 0; m_burst = 0;
      end else begin
         m_ta = 0; m_tea = 0; m_retry = 0; m_bi = 0; ctl_wr = 0; lock_ld = 0;
         nx_halt = m_halt; nx_shared = m_shared;
         if (m_fwd == 0) begin
            if (ext_ts && ext_bg && ext_addr[23:20] == map_base) begin
               if (ext_addr[19:2] == 0) begin
                  m_ta = 1; m_bi = ext_burst;
                  if (ext_we) begin ctl_wr = 1; nx_halt = ext_wdata[1]; nx_shared = ext_wdata[0]; end
                  else m_rdata = m_halt * 2 + m_shared;
               end else if (m_halt || m_shared) begin
                  if (ie_busy) begin m_retry = 1; m_lock = 8; lock_ld = 1; end
                  else begin
                     m_fwd = 1; m_cnt = 0; m_sz = ext_size; m_a = ext_addr[1:0];
                     m_we = ext_we; m_burst = ext_burst;
                  end
               end
            end
         end else begin
            if (int_ack) begin
               m_ta = 1; m_bi = m_burst; m_fwd = 0;
               if (!m_we) m_rdata = int_rdata;
            end else if (int_err || m_cnt == 15) begin
               m_tea = 1; m_bi = m_burst; m_fwd = 0;
            end else m_cnt++;
         end
         if (!lock_ld && m_lock > 0) m_lock--;
         if (ctl_wr) begin m_halt = nx_halt; m_shared = nx_shared; end
         else if (sw_we) begin m_halt = sw_wdata[1]; m_shared = sw_wdata[0]; end
      end
   end

   function automatic logic [3:0] exp_be(int sz, int a);
      if (sz == 0) return 4'(1 << (3 - a));
      if (sz == 1) return (a >= 2) ? 4'b0011 : 4'b1100;
      return 4'b1111;
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R5 ta", 32'(ext_ta), 32'(m_ta));
         check("R8 R11 tea", 32'(ext_tea), 32'(m_tea));
         check("R6 retry", 32'(ext_retry), 32'(m_retry));
         check("R3 bi", 32'(ext_bi), 32'(m_bi));
         check("R1 halt", 32'(cpu_halt), 32'(m_halt));
         check("R2 R7 gnt", 32'(cpu_gnt), 32'(cpu_req && !m_halt && m_lock == 0 && m_fwd == 0));
         check("R4 R12 req", 32'(int_req), 32'(m_fwd));
         if (m_fwd != 0) check("R9 be", 32'(int_be), 32'(exp_be(m_sz, m_a)));
         if (m_ta != 0 && (m_we == 0 || m_fwd == 0)) check("R10 R12 rdata", ext_rdata, m_rdata);
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(int n = 1);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic ext_start(logic [23:0] a, logic we, logic [1:0] sz, logic bst, logic [31:0] wd);
      ext_ts = 1; ext_addr = a; ext_we = we; ext_size = sz; ext_burst = bst; ext_wdata = wd;
      cyc();
      ext_ts = 0; ext_burst = 0;
   endtask

   task automatic reply(int wait_n, bit err);
      cyc(wait_n);
      if (err) int_err = 1; else int_ack = 1;
      cyc();
      int_ack = 0; int_err = 0;
      cyc(2);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset into halted-core mode
      cyc(3);
      rst_n = 1;
      #1;
      check("R1 reset halt", 32'(cpu_halt), 1);
      check("R1 no gnt while halted", 32'(cpu_gnt), 0);
      cyc(2);
      ext_bg = 1;

      // R10: read then write the mode register
      ext_start(24'h300000, 0, 2'd2, 0, 0);
      check("R10 ctrl read ta", 32'(ext_ta), 1);
      check("R10 ctrl read value", ext_rdata, 32'h2);
      cyc(2);
      ext_start(24'h300000, 1, 2'd2, 0, 32'h1);   // shared mode
      cyc(2);
      check("R2 shared mode grants cpu", 32'(cpu_gnt), 1);

      // R12/R9: forwarded word write, then byte and half lanes
      ext_start(24'h300100, 1, 2'd2, 0, 32'h1122_3344);
      check("R12 int_req after start", 32'(int_req), 1);
      check("R12 int_wdata", int_wdata, 32'h1122_3344);
      reply(2, 0);
      for (int a = 0; a < 4; a++) begin
         ext_start(24'h300200 + 24'(a), 1, 2'd0, 0, 32'hAA);
         check("R9 byte lane", 32'(int_be), 32'(4'b1000 >> a));
         reply(0, 0);
      end
      ext_start(24'h300202, 1, 2'd1, 0, 0);
      check("R9 half lane high addr", 32'(int_be), 32'h3);
      reply(1, 0);
      ext_start(24'h300200, 0, 2'd1, 0, 0);
      check("R9 half lane low addr", 32'(int_be), 32'hC);
      reply(0, 0);

      // R12: forwarded read returns slave data
      int_rdata = 32'h5A5A_0F0F;
      ext_start(24'h300300, 0, 2'd2, 0, 0);
      reply(3, 0);

      // R3: burst attempt
      ext_start(24'h300400, 0, 2'd2, 1, 0);
      cyc(1);
      int_ack = 1; cyc(); int_ack = 0;
      check("R3 bi with ta", 32'(ext_bi & ext_ta), 1);
      cyc(2);

      // R11: slave error
      ext_start(24'h300500, 1, 2'd2, 0, 0);
      reply(1, 1);

      // R8: no response, timeout
      ext_start(24'h300600, 0, 2'd2, 0, 0);
      cyc(15);
      check("R8 still waiting", 32'(ext_tea), 0);
      cyc(1);
      check("R8 timeout error", 32'(ext_tea), 1);
      cyc(2);

      // R6/R7: deadlock retry and lockout
      ie_busy = 1;
      ext_start(24'h300700, 0, 2'd2, 0, 0);
      ie_busy = 0;
      check("R6 retry", 32'(ext_retry), 1);
      check("R7 lockout", 32'(cpu_gnt), 0);
      cyc(8);
      check("R7 lockout released", 32'(cpu_gnt), 1);

      // R4: misses
      ext_start(24'h500100, 0, 2'd2, 0, 0);       // wrong base
      check("R4 base miss", 32'(int_req), 0);
      ext_bg = 0;
      ext_start(24'h300100, 0, 2'd2, 0, 0);       // no grant
      check("R4 no grant", 32'(int_req), 0);
      ext_bg = 1;
      map_base = 4'h5;
      ext_start(24'h500100, 1, 2'd2, 0, 0);       // relocated window
      check("R4 relocated hit", 32'(int_req), 1);
      reply(0, 0);

      // R1: CPU writes halted-core mode
      sw_we = 1; sw_wdata = 2'b10; cyc(); sw_we = 0;
      check("R1 sw halt", 32'(cpu_halt), 1);
      cyc(2);

      // R4/R10: reset with both modes off
      rst_n = 0; cfg_halt_rst = 0; cyc(2); rst_n = 1; cyc(1);
      check("R1 reset shared off", 32'(cpu_halt), 0);
      ext_start(24'h500100, 0, 2'd2, 0, 0);
      check("R4 mode off ignores", 32'(int_req), 0);
      cyc(2);
      ext_start(24'h500000, 0, 2'd2, 0, 0);
      check("R10 ctrl reachable when off", 32'(ext_ta), 1);
      check("R10 ctrl value off", ext_rdata, 32'h0);
      cyc(4);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule